// File: doc/BRIEF.md
# Debug Port Unlock Gate

This block decides whether an external debug port may be opened. Its inputs are one-time configuration bits: a lifecycle bit that selects development or production, a permanent kill bit, and a bit that arms key-based unlocking. It also takes a 64-bit stored key and that key's read-lock bit. The gate applies a fixed priority order. The kill bit closes the port before anything else is considered. Development lifecycle opens the port. In production, the port opens only after a successful key unlock.

A debugger shifts its candidate key in serially, least significant bit first, over a data/valid pair. It then pulses a compare strobe. A match sets a sticky unlocked flag. A mismatch sets a fail flag and starts a fixed lockout window, during which further strobes have no effect. A separate software read port returns the stored key, or all zeros once the key's lock bit is set.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: With kill low and lifecycle in development (`cfg_prod`=0), `dbg_enable` is 1 from the first clock edge after those inputs are applied, with no key supplied.
- R2: With `cfg_prod`=1, `cfg_keyed`=1 and kill low, `dbg_enable` is 0 until `unlocked` is 1, and becomes 1 one edge after `unlocked` rises.
- R3: Each cycle with `key_sh_valid`=1 shifts `key_sh_data` into a 64-bit register, least significant bit first: the first bit of 64 lands in bit 0. A `key_cmp` strobe that is accepted sets `unlocked` at the next edge when the register equals `cfg_key`.
- R4: The kill input has top priority. One edge after `cfg_kill`=1, `dbg_enable` is 0, whatever the lifecycle, the arming bit or `unlocked` is.
- R5: Once `cfg_kill` has been seen high, `dbg_enable` stays 0 until reset, even after `cfg_kill` returns to 0.
- R6: A cycle with `sw_rd`=1 loads `sw_rd_data` at the next edge. It loads `cfg_key` when `cfg_key_lock`=0 and all zeros when `cfg_key_lock`=1. Otherwise `sw_rd_data` holds its value.
- R7: `unlocked` clears only on reset, and strobes made while unlocked change nothing. An accepted strobe whose key does not match sets `fail` at the next edge and leaves `unlocked` at 0. A later successful compare clears `fail`.
- R8: After a failed compare, `lockout` is 1 for exactly 1024 cycles, starting the edge after the strobe. Strobes made while `lockout` is 1 leave `unlocked` and `fail` unchanged.
- R9: With `cfg_prod`=1 and `cfg_keyed`=0, `dbg_enable` stays 0. Strobes are ignored: `unlocked`, `fail` and `lockout` do not change.
- R10: While `rst` is high at an edge, `dbg_enable`, `unlocked`, `fail`, `lockout` and `sw_rd_data` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prod | input | 1 | Lifecycle: 0 development, 1 production |
| cfg_kill | input | 1 | Permanent debug disable |
| cfg_keyed | input | 1 | Arms key-based unlocking in production |
| cfg_key | input | 64 | Stored debug key |
| cfg_key_lock | input | 1 | Hides the key from software reads |
| key_sh_data | input | 1 | Serial candidate key bit |
| key_sh_valid | input | 1 | Shift enable for `key_sh_data` |
| key_cmp | input | 1 | One-cycle compare strobe |
| sw_rd | input | 1 | Software key read request |
| sw_rd_data | output | 64 | Registered software read result |
| dbg_enable | output | 1 | Debug port enable |
| unlocked | output | 1 | Sticky key-unlock flag |
| fail | output | 1 | Last accepted compare mismatched |
| lockout | output | 1 | Compare lockout window active |

## Verification
Outputs are due on fixed cycles. The flags (`unlocked`, `fail`, `lockout`) and `sw_rd_data` settle one edge after the strobe or read. `dbg_enable` settles one edge after a configuration change, and therefore two edges after a successful strobe. The bench drives inputs on the falling edge and samples on the following falling edge, so each check sees exactly one or two rising edges. The lockout length is measured by counting falling edges at which `lockout` is high. A strobe is placed in the middle of that window to confirm it is ignored.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int unsigned KEY_W_DEF   = 64;
  localparam int unsigned LOCKOUT_DEF = 1024;

  typedef enum logic [1:0] {
    GATE_KILLED = 2'd0,
    GATE_DEV    = 2'd1,
    GATE_KEYED  = 2'd2,
    GATE_CLOSED = 2'd3
  } gate_state_e;
endpackage

// File: rtl/dbg_key_shifter.sv
module dbg_key_shifter #(
  parameter int unsigned KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sh_data,
  input  logic             sh_valid,
  output logic [KEY_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)
      word <= '0;
    else if (sh_valid)
      word <= {sh_data, word[KEY_W-1:1]};
  end
endmodule

// File: rtl/dbg_unlock_unit.sv
module dbg_unlock_unit #(
  parameter int unsigned KEY_W   = 64,
  parameter int unsigned LOCKOUT = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             strobe,
  input  logic [KEY_W-1:0] cand,
  input  logic [KEY_W-1:0] ref_key,
  output logic             unlocked,
  output logic             fail,
  output logic             busy
);
  localparam int unsigned CNT_W = $clog2(LOCKOUT + 1);

  logic [CNT_W-1:0] cnt;
  logic             take;

  assign busy = (cnt != '0);
  assign take = strobe && armed && !busy && !unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      fail     <= 1'b0;
      cnt      <= '0;
    end else begin
      if (busy)
        cnt <= cnt - 1'b1;
      if (take) begin
        if (cand == ref_key) begin
          unlocked <= 1'b1;
          fail     <= 1'b0;
        end else begin
          fail <= 1'b1;
          cnt  <= CNT_W'(LOCKOUT);
        end
      end
    end
  end

  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked); // R7
  AST_LOCKOUT_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && strobe) |=> ($stable(unlocked) && $stable(fail))); // R8
  AST_UNARMED_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!armed && !busy && !unlocked) |=> !unlocked); // R9
  AST_FAIL_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> !unlocked); // R7
endmodule

// File: rtl/dbg_key_readport.sv
module dbg_key_readport #(
  parameter int unsigned KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             lock,
  input  logic [KEY_W-1:0] key,
  output logic [KEY_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd)
      rd_data <= lock ? '0 : key;
  end

  AST_RD_MASKED: assert property (@(posedge clk) disable iff (rst)
    (rd && lock) |=> (rd_data == '0)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rd_data)); // R6
endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_gate_pkg::*;
#(
  parameter int unsigned KEY_W   = KEY_W_DEF,
  parameter int unsigned LOCKOUT = LOCKOUT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_prod,
  input  logic             cfg_kill,
  input  logic             cfg_keyed,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic             cfg_key_lock,
  input  logic             key_sh_data,
  input  logic             key_sh_valid,
  input  logic             key_cmp,
  input  logic             sw_rd,
  output logic [KEY_W-1:0] sw_rd_data,
  output logic             dbg_enable,
  output logic             unlocked,
  output logic             fail,
  output logic             lockout
);
  logic [KEY_W-1:0] cand;
  logic             kill_seen;
  gate_state_e      gate;

  dbg_key_shifter #(.KEY_W(KEY_W)) u_shift (
    .clk(clk), .rst(rst), .sh_data(key_sh_data), .sh_valid(key_sh_valid),
    .word(cand)
  );

  dbg_unlock_unit #(.KEY_W(KEY_W), .LOCKOUT(LOCKOUT)) u_unlock (
    .clk(clk), .rst(rst), .armed(cfg_prod && cfg_keyed), .strobe(key_cmp),
    .cand(cand), .ref_key(cfg_key), .unlocked(unlocked), .fail(fail),
    .busy(lockout)
  );

  dbg_key_readport #(.KEY_W(KEY_W)) u_rd (
    .clk(clk), .rst(rst), .rd(sw_rd), .lock(cfg_key_lock), .key(cfg_key),
    .rd_data(sw_rd_data)
  );

  always_comb begin
    if (cfg_kill || kill_seen)  gate = GATE_KILLED;
    else if (!cfg_prod)         gate = GATE_DEV;
    else if (cfg_keyed)         gate = GATE_KEYED;
    else                        gate = GATE_CLOSED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_seen  <= 1'b0;
      dbg_enable <= 1'b0;
    end else begin
      if (cfg_kill)
        kill_seen <= 1'b1;
      case (gate)
        GATE_DEV:   dbg_enable <= 1'b1;
        GATE_KEYED: dbg_enable <= unlocked;
        default:    dbg_enable <= 1'b0;
      endcase
    end
  end

  AST_KILL_OFF: assert property (@(posedge clk) disable iff (rst)
    cfg_kill |=> !dbg_enable); // R4
  AST_KILL_STAYS: assert property (@(posedge clk) disable iff (rst)
    kill_seen |=> (kill_seen && !dbg_enable)); // R5
  AST_PROD_UNKEYED_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_prod && !cfg_keyed) |=> !dbg_enable); // R9
  AST_KEYED_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (cfg_prod && !unlocked) |=> !dbg_enable); // R2
endmodule

// File: tb/dbg_gate_ctrl_bench.sv
module dbg_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] GOOD_KEY = 64'hA5C3_1F0E_7B29_D486;
  localparam logic [63:0] BAD_KEY  = 64'hA5C3_1F0E_7B29_D487;

  // {prod, keyed, kill, expected dbg_enable}; kill rows last since kill latches
  localparam logic [3:0] LADDER [8] = '{
    4'b0001, 4'b0101, 4'b1000, 4'b1100,
    4'b0010, 4'b0110, 4'b1010, 4'b1110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_prod = 1'b0, cfg_kill = 1'b0, cfg_keyed = 1'b0, cfg_key_lock = 1'b0;
  logic [63:0] cfg_key = GOOD_KEY;
  logic key_sh_data = 1'b0, key_sh_valid = 1'b0, key_cmp = 1'b0, sw_rd = 1'b0;
  logic [63:0] sw_rd_data;
  logic dbg_enable, unlocked, fail, lockout;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_gate_ctrl u_dbg_gate_ctrl (
    .clk(clk), .rst(rst), .cfg_prod(cfg_prod), .cfg_kill(cfg_kill),
    .cfg_keyed(cfg_keyed), .cfg_key(cfg_key), .cfg_key_lock(cfg_key_lock),
    .key_sh_data(key_sh_data), .key_sh_valid(key_sh_valid), .key_cmp(key_cmp),
    .sw_rd(sw_rd), .sw_rd_data(sw_rd_data), .dbg_enable(dbg_enable),
    .unlocked(unlocked), .fail(fail), .lockout(lockout)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic shift_key(input logic [63:0] k);
    for (int i = 0; i < 64; i++) begin
      key_sh_data = k[i];
      key_sh_valid = 1'b1;
      step();
    end
    key_sh_valid = 1'b0;
  endtask

  task automatic strobe();
    key_cmp = 1'b1;
    step();
    key_cmp = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    step();
    do_reset();
    // R10 reset state
    check("R10 en", dbg_enable, 0);
    check("R10 unl", unlocked, 0);
    check("R10 fail", fail, 0);
    check("R10 lockout", lockout, 0);
    check("R10 rd", sw_rd_data, 0);

    // R1 R4 R9 priority ladder table
    foreach (LADDER[i]) begin
      cfg_prod = LADDER[i][3];
      cfg_keyed = LADDER[i][2];
      cfg_kill = LADDER[i][1];
      step();
      check("R1/R4/R9 ladder", dbg_enable, LADDER[i][0]);
    end
    // R5 kill released, still closed in development
    cfg_kill = 1'b0; cfg_prod = 1'b0;
    step(); step();
    check("R5 kill irreversible", dbg_enable, 0);
    do_reset();
    step();
    check("R1 dev open after reset", dbg_enable, 1);

    // R6 read port
    sw_rd = 1'b1; cfg_key_lock = 1'b0;
    step();
    check("R6 unlocked read", sw_rd_data, GOOD_KEY);
    cfg_key_lock = 1'b1;
    step();
    check("R6 locked read", sw_rd_data, 0);
    sw_rd = 1'b0; cfg_key_lock = 1'b0;
    step();
    check("R6 hold", sw_rd_data, 0);

    // R9 production, not armed: strobe ignored
    cfg_prod = 1'b1; cfg_keyed = 1'b0;
    shift_key(GOOD_KEY);
    strobe();
    check("R9 unl", unlocked, 0);
    check("R9 fail", fail, 0);
    check("R9 lockout", lockout, 0);
    step();
    check("R9 en", dbg_enable, 0);

    // R7 R8 wrong key
    cfg_keyed = 1'b1;
    shift_key(BAD_KEY);
    strobe();
    check("R7 fail set", fail, 1);
    check("R7 still locked", unlocked, 0);
    check("R8 lockout start", lockout, 1);
    check("R2 closed", dbg_enable, 0);
    n = 0;
    while (lockout && n < 2000) begin
      key_sh_valid = (n < 64);
      key_sh_data = (n < 64) ? GOOD_KEY[n % 64] : 1'b0;
      key_cmp = (n == 100);
      step();
      n++;
      if (n == 101) begin
        check("R8 strobe ignored unl", unlocked, 0);
        check("R8 strobe ignored fail", fail, 1);
      end
    end
    key_sh_valid = 1'b0; key_cmp = 1'b0;
    check("R8 lockout length", n, 1024);

    // R3 R2 good key (already shifted LSB first) unlocks
    strobe();
    check("R3 unlocked", unlocked, 1);
    check("R7 fail cleared", fail, 0);
    check("R2 en lags", dbg_enable, 0);
    step();
    check("R2 en open", dbg_enable, 1);

    // R7 sticky
    shift_key(BAD_KEY);
    strobe();
    check("R7 sticky unl", unlocked, 1);
    check("R7 no fail when unlocked", fail, 0);

    // R4 R5 kill dominates unlock
    cfg_kill = 1'b1;
    step();
    check("R4 kill over unlock", dbg_enable, 0);
    cfg_kill = 1'b0;
    step(); step();
    check("R5 stays closed", dbg_enable, 0);
    check("R7 unl kept", unlocked, 1);

    do_reset();
    check("R10 unl reset", unlocked, 0);
    check("R10 en reset", dbg_enable, 0);
    finish_run();
  end
endmodule